// File: doc/BRIEF.md
# TDM Serial Output Lane with Buffer Control

This block turns per-channel bytes into one time-division-multiplexed serial output stream. The stream can run at 2.048, 4.096 or 8.192 Mb/s. A second output tells an external three-state buffer, slot by slot, whether the current channel is driven or floated. A bitmap supplies one enable bit per channel. A frame strobe marks channel 0, and a 16.384 MHz bit-rate enable paces the bits. The block reads channel bytes through a simple read port. That port returns data in the same cycle the address is presented.

Each channel is a byte, sent most significant bit first. The byte and its enable bit are fetched one bit period before the slot begins. Because of this, the data and the buffer-control line switch on the same edge. Three-state behaviour appears as a separate data-enable output. A global drive-enable input reaches the outputs through gates only, with no register in the path. When it is low, the stream is floated and the buffer-control line is held high, at once and without waiting for a clock.

The fetch for channel 0 takes place in the last slot of the previous frame. For that reason the frame strobe is expected to repeat every 2048 bit-rate enables. The first frame after reset is a warm-up frame.

Top module: `tdm_tx_lane`

## Requirements
- R1: After reset, and before any slot has been loaded, `sdo_oe` is 0, `hiz_ctl` is 1 and `sdo` is 0.
- R2: `rate_sel` code 0 holds each bit for 8 bit-rate enables (2.048 Mb/s), code 1 for 4 and code 2 for 2. Reserved code 3 behaves like code 0.
- R3: A frame carries 32, 64 or 128 channels for codes 0, 1 and 2. The bit-rate enable that carries `frame_start` starts bit 7 of channel 0, and the output changes on that same edge.
- R4: Each channel sends its byte from `rd_data` most significant bit first, one bit per bit period, on `sdo`.
- R5: For an enabled channel (`ch_enable[c]`=1) with `drive_en` high, `sdo_oe` is 1 and `hiz_ctl` is 0 for the whole slot.
- R6: For a disabled channel, `sdo_oe` is 0, `hiz_ctl` is 1 and `sdo` is 0 for the whole slot.
- R7: While `drive_en` is low, `sdo_oe` is 0, `hiz_ctl` is 1 and `sdo` is 0, with no clock edge needed.
- R8: Taking `drive_en` low does not disturb the bit timing. When it returns high, the outputs at once show the slot the frame has reached.
- R9: A change of `rate_sel` in the middle of a frame has no effect until the next `frame_start`.
- R10: `rd_addr` always shows the channel after the current one, wrapping to 0 after the last channel of the frame's rate. Byte and enable bit are captured at the start of the current slot's last bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | 16.384 MHz bit-rate enable, one cycle wide |
| frame_start | input | 1 | Frame strobe, valid only together with `bit_tick` |
| rate_sel | input | 2 | Stream rate code: 0 = 2.048, 1 = 4.096, 2 = 8.192 Mb/s, 3 = as 0 |
| drive_en | input | 1 | Asynchronous global output drive enable, active high |
| ch_enable | input | 128 | Per-channel enable bitmap, bit c for channel c |
| rd_data | input | 8 | Byte for the channel at `rd_addr`, same cycle |
| rd_addr | output | 7 | Channel whose byte is wanted next |
| sdo | output | 1 | Serial data, 0 when not driven |
| sdo_oe | output | 1 | Data-enable for `sdo` |
| hiz_ctl | output | 1 | External buffer control: 1 = float the slot, 0 = drive |

## Verification
The bench checks every bit period against a model built from the channel index and bit index. A design that fetched too late would shift the whole stream by one slot. One that got the MSB order wrong would send each byte mirrored. One that wrapped the channel count at the wrong rate would lose channel 0 alignment in the next frame. The rate code is changed in the middle of a frame, so a design that applied it at once would break up that frame. The frames include an all-enabled case, an all-disabled case and the reserved rate code. The bench also pulses the drive enable between clock edges. A registered override would lag the pin by one edge. An override that also stopped the timing would come back on the wrong slot.

// File: rtl/tdm_lane_pkg.sv
// Package: shared rate codes and helpers for the TDM output lane.
// Assumes the rate is a 2-bit code; the reserved code maps to the slowest rate.
package tdm_lane_pkg;

    typedef enum logic [1:0] {
        RATE_2M  = 2'd0,
        RATE_4M  = 2'd1,
        RATE_8M  = 2'd2,
        RATE_RSV = 2'd3
    } rate_e;

    // Normalise a raw rate code; the reserved value behaves as the slowest rate.
    function automatic logic [1:0] rate_norm(input logic [1:0] code);
        return (code == RATE_RSV) ? RATE_2M : code;
    endfunction

endpackage

// File: rtl/tdm_bit_timer.sv
// Module: bit, slot and frame timing for one TDM output lane.
// Divides the bit-rate enable by BASE_DIV >> rate, counts BITS bits per slot
// and (MAX_CH >> 2) << rate slots per frame. It latches the rate on every frame strobe.
// Assumes frame_start is only meaningful in a cycle with bit_tick high.
module tdm_bit_timer
    import tdm_lane_pkg::*;
#(
    parameter int BASE_DIV = 8,
    parameter int MAX_CH   = 128,
    parameter int BITS     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_tick,
    input  logic                       frame_start,
    input  logic [1:0]                 rate_sel,
    output logic [$clog2(MAX_CH)-1:0]  next_ch,
    output logic                       load_slot,
    output logic                       shift_bit,
    output logic                       fetch_next
);
    localparam int DIV_W = $clog2(BASE_DIV);
    localparam int BIT_W = $clog2(BITS);
    localparam int CH_W  = $clog2(MAX_CH);

    logic [1:0]       rate_q;
    logic [DIV_W-1:0] tick_cnt;
    logic [BIT_W-1:0] bit_idx;
    logic [CH_W-1:0]  ch_idx;
    logic [DIV_W:0]   div_len;
    logic [CH_W:0]    nch;
    logic             last_tick;
    logic             boundary;
    logic [BIT_W-1:0] bit_nxt;

    // Ticks per bit and channels per frame for the latched rate.
    assign div_len = (DIV_W+1)'(BASE_DIV) >> rate_q;
    assign nch     = (CH_W+1)'(MAX_CH) >> (2'd2 - rate_q);

    // Bit-period boundary: the divider wraps or a frame strobe arrives.
    assign last_tick = ({1'b0, tick_cnt} == div_len - 1'b1);
    assign boundary  = bit_tick & (frame_start | last_tick);

    // Next bit position and the slot events it implies.
    assign bit_nxt    = frame_start ? '0 :
                        (bit_idx == BIT_W'(BITS-1)) ? '0 : bit_idx + 1'b1;
    assign load_slot  = boundary & (bit_nxt == '0);
    assign shift_bit  = boundary & (bit_nxt != '0);
    assign fetch_next = boundary & ~frame_start & (bit_nxt == BIT_W'(BITS-1));

    // Channel after the current one, wrapping at the frame's channel count.
    assign next_ch = ({1'b0, ch_idx} == nch - 1'b1) ? '0 : ch_idx + 1'b1;

    // Advance divider, bit and channel counters; restart all on a frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q   <= RATE_2M;
            tick_cnt <= '0;
            bit_idx  <= '0;
            ch_idx   <= '0;
        end else if (bit_tick) begin
            if (frame_start) begin
                rate_q <= rate_norm(rate_sel);
            end
            if (boundary) begin
                tick_cnt <= '0;
                bit_idx  <= bit_nxt;
                if (frame_start) begin
                    ch_idx <= '0;
                end else if (bit_idx == BIT_W'(BITS-1)) begin
                    ch_idx <= next_ch;
                end
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // R3: channel index stays inside the frame of the latched rate.
    a_r3_ch_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, ch_idx} < nch));

    // R3: a frame strobe restarts channel, bit and divider.
    a_r3_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && frame_start) |=> (ch_idx == '0 && bit_idx == '0 && tick_cnt == '0));

    // R9: the latched rate only moves on a frame strobe.
    a_r9_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick && frame_start) |=> $stable(rate_q));

    // R2: divider never exceeds the period of the current rate.
    a_r2_tick_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, tick_cnt} < div_len));

endmodule

// File: rtl/tdm_slot_fetch.sv
// Module: one-slot lookahead fetch of channel byte and enable bit.
// Presents the next channel on the read port at all times. It captures data and
// enable when fetch_next fires, at the start of the last bit of the current slot.
// Assumes the read port returns data combinationally.
module tdm_slot_fetch #(
    parameter int MAX_CH = 128,
    parameter int BITS   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fetch_next,
    input  logic [$clog2(MAX_CH)-1:0] next_ch,
    input  logic [BITS-1:0]           rd_data,
    input  logic [MAX_CH-1:0]         ch_enable,
    output logic [$clog2(MAX_CH)-1:0] rd_addr,
    output logic [BITS-1:0]           stage_data,
    output logic                      stage_en
);
    // Read address is the channel to be sent next.
    assign rd_addr = next_ch;

    // Capture the next slot's byte and enable bit one bit period early.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_data <= '0;
            stage_en   <= 1'b0;
        end else if (fetch_next) begin
            stage_data <= rd_data;
            stage_en   <= ch_enable[next_ch];
        end
    end

    // R10: staged values hold between fetches.
    a_r10_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_next |=> ($stable(stage_data) && $stable(stage_en)));

endmodule

// File: rtl/tdm_slot_shifter.sv
// Module: slot shift register and slot-active flag.
// Loads the staged byte and enable at a slot start, then shifts left once per bit.
// The MSB is the current serial bit. Assumes load and shift never coincide.
module tdm_slot_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_slot,
    input  logic            shift_bit,
    input  logic [BITS-1:0] stage_data,
    input  logic            stage_en,
    output logic            bit_out,
    output logic            slot_active
);
    logic [BITS-1:0] shreg;

    // Load a new slot or move to the next bit, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg       <= '0;
            slot_active <= 1'b0;
        end else if (load_slot) begin
            shreg       <= stage_data;
            slot_active <= stage_en;
        end else if (shift_bit) begin
            shreg <= {shreg[BITS-2:0], 1'b0};
        end
    end

    assign bit_out = shreg[BITS-1];

    // R4: after a shift the output bit is the previous second bit.
    a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        shift_bit |=> (bit_out == $past(shreg[BITS-2])));

    // R5: slot state is steady for the whole slot.
    a_r5_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_slot |=> $stable(slot_active));

endmodule

// File: rtl/tdm_tx_lane.sv
// Module: TDM serial output lane with external buffer control (top).
// Ties timer, fetch and shifter together and applies the asynchronous drive
// enable to data, data-enable and buffer control. drive_en has no register.
// Assumes frame_start repeats every (BASE_DIV * BITS * MAX_CH / 4) bit ticks.
module tdm_tx_lane #(
    parameter int BASE_DIV = 8,
    parameter int MAX_CH   = 128,
    parameter int BITS     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bit_tick,
    input  logic                      frame_start,
    input  logic [1:0]                rate_sel,
    input  logic                      drive_en,
    input  logic [MAX_CH-1:0]         ch_enable,
    input  logic [BITS-1:0]           rd_data,
    output logic [$clog2(MAX_CH)-1:0] rd_addr,
    output logic                      sdo,
    output logic                      sdo_oe,
    output logic                      hiz_ctl
);
    localparam int CH_W = $clog2(MAX_CH);

    logic [CH_W-1:0] next_ch;
    logic            load_slot;
    logic            shift_bit;
    logic            fetch_next;
    logic [BITS-1:0] stage_data;
    logic            stage_en;
    logic            bit_out;
    logic            slot_active;

    tdm_bit_timer #(.BASE_DIV(BASE_DIV), .MAX_CH(MAX_CH), .BITS(BITS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .frame_start(frame_start),
        .rate_sel   (rate_sel),
        .next_ch    (next_ch),
        .load_slot  (load_slot),
        .shift_bit  (shift_bit),
        .fetch_next (fetch_next)
    );

    tdm_slot_fetch #(.MAX_CH(MAX_CH), .BITS(BITS)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_next(fetch_next),
        .next_ch   (next_ch),
        .rd_data   (rd_data),
        .ch_enable (ch_enable),
        .rd_addr   (rd_addr),
        .stage_data(stage_data),
        .stage_en  (stage_en)
    );

    tdm_slot_shifter #(.BITS(BITS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_slot  (load_slot),
        .shift_bit  (shift_bit),
        .stage_data (stage_data),
        .stage_en   (stage_en),
        .bit_out    (bit_out),
        .slot_active(slot_active)
    );

    // Output gating: the drive enable overrides the slot state without a clock.
    assign sdo_oe  = drive_en & slot_active;
    assign hiz_ctl = ~sdo_oe;
    assign sdo     = sdo_oe & bit_out;

    // R7: a low drive enable forces the buffer off.
    a_r7_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (hiz_ctl && !sdo_oe && !sdo));

    // R5: with drive enabled, buffer control only moves after a slot load.
    a_r5_ctl_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && !load_slot) |=> (!drive_en || $stable(hiz_ctl)));

endmodule

// File: tb/tb_tdm_tx_lane.sv
// Bench: drives periodic frames at all rates, random channel content and a few
// directed cases. Compares every bit period with a model computed from the
// requirements.
module tb_tdm_tx_lane;
    localparam int MAX_CH      = 128;
    localparam int BITS        = 8;
    localparam int CH_W        = 7;
    localparam int FRAME_TICKS = 2048;
    localparam int NFRAMES     = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             bit_tick;
    logic             frame_start;
    logic [1:0]       rate_sel;
    logic             drive_en;
    logic [MAX_CH-1:0] ch_enable;
    logic [BITS-1:0]  rd_data;
    logic [CH_W-1:0]  rd_addr;
    logic             sdo, sdo_oe, hiz_ctl;

    logic [7:0] mem [MAX_CH];

    int errors = 0;
    int checks = 0;
    int pos = 0;
    int frame_rate = 0;
    bit model_valid = 0;
    bit de = 1;
    bit mid_change = 0;

    always #4 clk = ~clk;

    assign rd_data = mem[rd_addr];

    tdm_tx_lane dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_start(frame_start),
        .rate_sel(rate_sel), .drive_en(drive_en), .ch_enable(ch_enable),
        .rd_data(rd_data), .rd_addr(rd_addr), .sdo(sdo), .sdo_oe(sdo_oe),
        .hiz_ctl(hiz_ctl)
    );

    function automatic int div_of(int r);
        return (r == 1) ? 4 : (r == 2) ? 2 : 8;
    endfunction

    function automatic int nch_of(int r);
        return (r == 1) ? 64 : (r == 2) ? 128 : 32;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (pos %0d)", req, what, act, exp, pos);
        end
    endtask

    // Compare all outputs with the model at the current frame position.
    task automatic check_outputs(input string force_tag);
        int n, c, b, act_en, e_oe, e_sdo;
        string t_sdo, t_ctl;
        n = div_of(frame_rate);
        c = pos / (BITS * n);
        b = (pos / n) % BITS;
        act_en = ch_enable[c];
        e_oe = de && act_en;
        e_sdo = e_oe ? mem[c][7-b] : 0;
        if (pos % (BITS * n) == 0)  t_sdo = "R3";
        else if (mid_change && pos % n == 0) t_sdo = "R9";
        else if (pos % n == 0)      t_sdo = "R2";
        else                        t_sdo = "R4";
        t_ctl = !de ? "R7" : (act_en ? "R5" : "R6");
        if (force_tag != "") begin
            t_sdo = force_tag;
            t_ctl = force_tag;
        end
        chk(t_sdo, "sdo", sdo, e_sdo);
        chk(t_ctl, "sdo_oe", sdo_oe, e_oe);
        chk(t_ctl, "hiz_ctl", hiz_ctl, !e_oe);
        chk("R10", "rd_addr", rd_addr, (c + 1) % nch_of(frame_rate));
    endtask

    // Refresh channels 1..MAX_CH-1; channel 0 was fetched in the last frame.
    task automatic refresh(input int mode);
        for (int i = 1; i < MAX_CH; i++) begin
            mem[i] = 8'($urandom);
            ch_enable[i] = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : 1'($urandom);
        end
    endtask

    initial begin
        int next_rate [NFRAMES] = '{1, 2, 3, 0, 2, 1, 0};
        int mode [NFRAMES]      = '{0, 0, 0, 0, 1, 2, 0};
        bit pulse [NFRAMES]     = '{0, 0, 1, 0, 0, 1, 0};
        void'($urandom(32'd2024));
        for (int i = 0; i < MAX_CH; i++) begin
            mem[i] = 8'($urandom);
            ch_enable[i] = 1'($urandom);
        end
        mem[0] = 8'hA5;
        ch_enable[0] = 1'b1;
        rst_n = 1'b0; bit_tick = 1'b0; frame_start = 1'b0;
        rate_sel = 2'd0; drive_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "sdo_oe after reset", sdo_oe, 0);
        chk("R1", "hiz_ctl after reset", hiz_ctl, 1);
        chk("R1", "sdo after reset", sdo, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "hiz_ctl idle", hiz_ctl, 1);

        for (int f = 0; f < NFRAMES; f++) begin
            for (int t = 0; t < FRAME_TICKS; t++) begin
                @(negedge clk);
                if (model_valid) check_outputs("");
                bit_tick = 1'b1;
                frame_start = (t == 0);
                if (t == 0) begin
                    frame_rate = rate_sel;
                    mid_change = 0;
                    model_valid = (f >= 1);
                    refresh(mode[f]);
                end
                if (t == 1000) begin
                    rate_sel = 2'(next_rate[f]);
                    mid_change = (next_rate[f] != frame_rate);
                end
                pos = t;
                @(negedge clk);
                bit_tick = 1'b0;
                frame_start = 1'b0;
                if (model_valid) check_outputs("");
                if (pulse[f] && t == 300) begin
                    #1 drive_en = 1'b0;
                    de = 0;
                    #1 chk("R7", "sdo_oe async", sdo_oe, 0);
                    chk("R7", "hiz_ctl async", hiz_ctl, 1);
                    chk("R7", "sdo async", sdo, 0);
                end
                if (pulse[f] && t == 340) begin
                    #1 drive_en = 1'b1;
                    de = 1;
                    #1 check_outputs("R8");
                end
            end
        end
        @(negedge clk);
        check_outputs("");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, all requirements unverified");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule